// File: doc/BRIEF.md
# Clock Guard Unit

This block holds the clock control state of a chip on a small memory-mapped register port. It switches three clock sources on and off: a fast crystal oscillator, a slow crystal oscillator and a frequency multiplier. It picks which source drives the system and holds back the system clock after the chip wakes from sleep. The real oscillators and the multiplier are stood in for by start-up models. Each model raises a ready flag once a set number of cycles has passed since its enable went high.

The control registers are guarded. A write anywhere in the control range is dropped unless a guard register holds the unlock key. The unlock then stays open for any number of writes, until some other value is written to the guard register.

When the chip goes to sleep, the system clock ready flag drops. On the wake event, a countdown loads from the option register and ticks once every 256 cycles, or once every 16 cycles in fast mode. The system clock is released when the countdown reaches zero.

Top module: `clk_guard_unit`

## Requirements
- R1: While the guard register at offset 0x24 does not hold 0x96, a write to any offset from 0x00 to 0x14 leaves every control register and every enable output unchanged. Reading back returns the old contents.
- R2: Writing 0x96 to offset 0x24 opens the control registers for any number of later writes. Writing any other value there closes them again. Offset 0x24 reads back the last value written, in bits 7:0.
- R3: At offset 0x08, bit 1 drives the fast oscillator enable and bit 0 drives the slow oscillator enable. At offset 0x0C, bit 0 drives the multiplier enable. Each enable output follows its bit one cycle after the write.
- R4: After reset, the following hold:
  - The guard register reads 0.
  - Offset 0x08 reads 0x0002, with only the fast oscillator enabled.
  - Offset 0x0C reads 0.
  - Offset 0x14 reads 0x8000.
  - The source select reads 0, and the active source is 0.
  - The system clock ready flag is high.
- R5: A source's ready flag (bit 0 fast, bit 1 slow, bit 2 multiplier) rises exactly START cycles after the write that set its enable. It clears one cycle after the enable is cleared.
- R6: Offset 0x00, bits 1:0, selects the source: 0 fast, 1 slow, 2 multiplier. The active source output takes the selected value only while that source's ready flag is high. Until then, the previous source stays active.
- R7: A sleep request drops the system clock ready flag on the next cycle. The flag stays low until a wake event arrives.
- R8: On a wake event, the countdown loads from offset 0x14 bits 15:8, and bit 2 picks fast mode. The ready flag rises exactly N×256 cycles after the wake cycle, or N×16 cycles in fast mode.
- R9: A countdown value of zero releases the system clock on the cycle right after the wake event.
- R10: If a write to offset 0x14 lands in the same cycle as the wake event, the countdown uses the field value held before that write. The new value is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset for read and write |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data for addr |
| sleep_req | input | 1 | Sleep entry pulse |
| wake_evt | input | 1 | Wake-up event pulse |
| hs_osc_en | output | 1 | Fast oscillator enable |
| ls_osc_en | output | 1 | Slow oscillator enable |
| pll_en | output | 1 | Frequency multiplier enable |
| src_ready | output | 3 | Per-source ready flags |
| active_src | output | 2 | Source currently driving the system |
| sys_clk_ready | output | 1 | System clock released |

## Verification
A register write and the wake event can land in the same cycle. The case of interest is a write that changes the countdown field or fast-mode bit while the wake event samples them. The bench raises `wr_en` to offset 0x14 and `wake_evt` on the same clock edge. It then times the release of `sys_clk_ready`: release must follow the old count, while a later read must return the new one. A second overlap is a source-select write while the chosen source is still starting. The bench judges it by checking that the active source holds until the ready flag rises.

// File: rtl/clkgu_pkg.sv
package clkgu_pkg;
  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_HS  = 2'd0,
    SRC_LS  = 2'd1,
    SRC_PLL = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_SLEEP = 2'd1,
    PH_WAIT  = 2'd2
  } phase_e;

  localparam logic [5:0] OFS_SEL = 6'h00;
  localparam logic [5:0] OFS_OSC = 6'h08;
  localparam logic [5:0] OFS_PLL = 6'h0C;
  localparam logic [5:0] OFS_OPT = 6'h14;
  localparam logic [5:0] OFS_KEY = 6'h24;
  localparam logic [7:0] UNLOCK_KEY = 8'h96;
endpackage

// File: rtl/clkgu_regs.sv
module clkgu_regs
  import clkgu_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter logic [7:0] WAIT_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        sel_q,
  output logic              hs_on,
  output logic              ls_on,
  output logic              pll_on,
  output logic [7:0]        wait_val,
  output logic              fast_mode,
  output logic              unlocked
);
  logic [7:0]        key_q;
  logic [1:0]        osc_q;
  logic              pll_q;
  logic [DATA_W-1:0] opt_q;
  logic [DATA_W-1:0] rd_mux;

  assign unlocked  = (key_q == UNLOCK_KEY);
  assign hs_on     = osc_q[1];
  assign ls_on     = osc_q[0];
  assign pll_on    = pll_q;
  assign wait_val  = opt_q[15:8];
  assign fast_mode = opt_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
      sel_q <= SRC_HS;
      osc_q <= 2'b10;
      pll_q <= 1'b0;
      opt_q <= DATA_W'({WAIT_RST, 8'h00});
    end else if (wr_en) begin
      if (addr == ADDR_W'(OFS_KEY)) begin
        key_q <= wr_data[7:0];
      end else if (unlocked) begin
        if (addr == ADDR_W'(OFS_SEL)) sel_q <= wr_data[1:0];
        if (addr == ADDR_W'(OFS_OSC)) osc_q <= wr_data[1:0];
        if (addr == ADDR_W'(OFS_PLL)) pll_q <= wr_data[0];
        if (addr == ADDR_W'(OFS_OPT)) opt_q <= wr_data;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(OFS_SEL)) rd_mux = DATA_W'(sel_q);
    if (addr == ADDR_W'(OFS_OSC)) rd_mux = DATA_W'(osc_q);
    if (addr == ADDR_W'(OFS_PLL)) rd_mux = DATA_W'(pll_q);
    if (addr == ADDR_W'(OFS_OPT)) rd_mux = opt_q;
    if (addr == ADDR_W'(OFS_KEY)) rd_mux = DATA_W'(key_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/clkgu_src_model.sv
module clkgu_src_model #(
  parameter int START_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic ready
);
  localparam int CW = $clog2(START_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (cnt == CW'(START_CYC - 1)) begin
      ready <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clkgu_wake_timer.sv
module clkgu_wake_timer
  import clkgu_pkg::*;
#(
  parameter int DIV_SLOW = 256,
  parameter int DIV_FAST = 16,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic             wake_evt,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_fast,
  output logic             sys_ready
);
  localparam int PW = $clog2(DIV_SLOW);

  phase_e         phase;
  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]  pre;
  logic           fast_q;
  logic [PW-1:0]  limit;

  assign limit = fast_q ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_RUN;
      sys_ready <= 1'b1;
      cnt       <= '0;
      pre       <= '0;
      fast_q    <= 1'b0;
    end else begin
      case (phase)
        PH_RUN: begin
          if (sleep_req) begin
            phase     <= PH_SLEEP;
            sys_ready <= 1'b0;
          end
        end
        PH_SLEEP: begin
          if (wake_evt) begin
            if (load_val == '0) begin
              phase     <= PH_RUN;
              sys_ready <= 1'b1;
            end else begin
              phase  <= PH_WAIT;
              cnt    <= load_val;
              fast_q <= load_fast;
              pre    <= '0;
            end
          end
        end
        PH_WAIT: begin
          if (pre == limit) begin
            pre <= '0;
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
              phase     <= PH_RUN;
              sys_ready <= 1'b1;
            end
          end else begin
            pre <= pre + 1'b1;
          end
        end
        default: phase <= PH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/clk_guard_unit.sv
module clk_guard_unit
  import clkgu_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int HS_START  = 1024,
  parameter int LS_START  = 4096,
  parameter int PLL_START = 512,
  parameter int DIV_SLOW  = 256,
  parameter int DIV_FAST  = 16,
  parameter logic [7:0] WAIT_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sleep_req,
  input  logic              wake_evt,
  output logic              hs_osc_en,
  output logic              ls_osc_en,
  output logic              pll_en,
  output logic [NUM_SRC-1:0] src_ready,
  output logic [1:0]        active_src,
  output logic              sys_clk_ready
);
  localparam int START_TAB [NUM_SRC] = '{HS_START, LS_START, PLL_START};

  logic [1:0]         sel_q;
  logic [7:0]         wait_val;
  logic               fast_mode;
  logic               unlocked;
  logic [NUM_SRC-1:0] en_vec;
  logic [3:0]         rdy_pad;

  clkgu_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_RST(WAIT_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .sel_q(sel_q), .hs_on(hs_osc_en), .ls_on(ls_osc_en),
    .pll_on(pll_en), .wait_val(wait_val), .fast_mode(fast_mode),
    .unlocked(unlocked)
  );

  assign en_vec = {pll_en, ls_osc_en, hs_osc_en};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    clkgu_src_model #(.START_CYC(START_TAB[g])) u_model (
      .clk(clk), .rst(rst), .en(en_vec[g]), .ready(src_ready[g])
    );
  end

  assign rdy_pad = {1'b0, src_ready};

  always_ff @(posedge clk) begin
    if (rst)                 active_src <= SRC_HS;
    else if (rdy_pad[sel_q]) active_src <= sel_q;
  end

  clkgu_wake_timer #(
    .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .CNT_W(8)
  ) u_timer (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .load_val(wait_val), .load_fast(fast_mode), .sys_ready(sys_clk_ready)
  );
endmodule

// File: rtl/clk_guard_unit_chk.sv
module clk_guard_unit_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        key_data,
  input logic              unlocked,
  input logic              hs_osc_en,
  input logic              ls_osc_en,
  input logic              pll_en,
  input logic [2:0]        src_ready,
  input logic [1:0]        active_src,
  input logic              sys_clk_ready,
  input logic              sleep_req
);
  logic [3:0] rdy_d;
  always_ff @(posedge clk) begin
    if (rst) rdy_d <= '0;
    else     rdy_d <= {1'b0, src_ready};
  end

  // R1
  a_r1_locked_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !unlocked && addr == ADDR_W'(6'h08)) |=> ($stable(hs_osc_en) && $stable(ls_osc_en)));
  // R2
  a_r2_key_opens: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(6'h24) && key_data == 8'h96) |=> unlocked);
  a_r2_other_closes: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(6'h24) && key_data != 8'h96) |=> !unlocked);
  // R5
  a_r5_hs_needs_en: assert property (@(posedge clk) disable iff (rst)
    src_ready[0] |-> $past(hs_osc_en));
  a_r5_ls_needs_en: assert property (@(posedge clk) disable iff (rst)
    src_ready[1] |-> $past(ls_osc_en));
  a_r5_pll_needs_en: assert property (@(posedge clk) disable iff (rst)
    src_ready[2] |-> $past(pll_en));
  // R6
  a_r6_switch_to_ready: assert property (@(posedge clk) disable iff (rst)
    (active_src != $past(active_src)) |-> rdy_d[active_src]);
  // R7
  a_r7_drop_on_sleep: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_clk_ready) |-> $past(sleep_req));
endmodule

bind clk_guard_unit clk_guard_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .key_data(wr_data[7:0]),
  .unlocked(unlocked), .hs_osc_en(hs_osc_en), .ls_osc_en(ls_osc_en),
  .pll_en(pll_en), .src_ready(src_ready), .active_src(active_src),
  .sys_clk_ready(sys_clk_ready), .sleep_req(sleep_req)
);

// File: tb/clk_guard_unit_tb.sv
module clk_guard_unit_tb;
  localparam int HS_S = 20, LS_S = 50, PLL_S = 30;

  logic        clk = 0, rst = 1;
  logic        wr_en = 0, sleep_req = 0, wake_evt = 0;
  logic [5:0]  addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic        hs_osc_en, ls_osc_en, pll_en, sys_clk_ready;
  logic [2:0]  src_ready;
  logic [1:0]  active_src;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  clk_guard_unit #(.HS_START(HS_S), .LS_START(LS_S), .PLL_START(PLL_S)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .hs_osc_en(hs_osc_en), .ls_osc_en(ls_osc_en), .pll_en(pll_en),
    .src_ready(src_ready), .active_src(active_src), .sys_clk_ready(sys_clk_ready)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] v);
    @(negedge clk); addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_sleep();
    @(negedge clk); sleep_req = 1;
    @(negedge clk); sleep_req = 0;
  endtask

  task automatic wake();
    @(negedge clk); wake_evt = 1;
    @(negedge clk); wake_evt = 0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(6'h24, v); chk("R4 guard", v, 16'h0);
    rd(6'h08, v); chk("R4 osc", v, 16'h0002);
    rd(6'h0C, v); chk("R4 pll", v, 16'h0);
    rd(6'h14, v); chk("R4 opt", v, 16'h8000);
    rd(6'h00, v); chk("R4 sel", v, 16'h0);
    chk("R4 enables", {hs_osc_en, ls_osc_en, pll_en}, 3'b100);
    chk("R4 sys ready", sys_clk_ready, 1'b1);
    chk("R4 active", active_src, 2'd0);
  endtask

  task automatic t_locked();
    logic [15:0] v;
    wr(6'h08, 16'h0003);
    wr(6'h14, 16'h1234);
    rd(6'h08, v); chk("R1 osc kept", v, 16'h0002);
    rd(6'h14, v); chk("R1 opt kept", v, 16'h8000);
    chk("R1 ls enable", ls_osc_en, 1'b0);
  endtask

  task automatic t_unlock_relock();
    logic [15:0] v;
    wr(6'h24, 16'h0096);
    rd(6'h24, v); chk("R2 guard readback", v, 16'h0096);
    wr(6'h08, 16'h0003);
    wr(6'h0C, 16'h0001);
    chk("R3 ls enable", ls_osc_en, 1'b1);
    chk("R3 pll enable", pll_en, 1'b1);
    chk("R3 hs enable", hs_osc_en, 1'b1);
    wr(6'h24, 16'h0055);
    wr(6'h0C, 16'h0000);
    chk("R2 relocked pll", pll_en, 1'b1);
    rd(6'h24, v); chk("R2 guard value", v, 16'h0055);
  endtask

  task automatic t_ready();
    wr(6'h24, 16'h0096);
    wr(6'h0C, 16'h0000);
    edges(2);
    chk("R5 pll ready cleared", src_ready[2], 1'b0);
    wr(6'h0C, 16'h0001);
    edges(PLL_S - 1);
    chk("R5 pll not yet ready", src_ready[2], 1'b0);
    edges(1);
    chk("R5 pll ready", src_ready[2], 1'b1);
  endtask

  task automatic t_select();
    wr(6'h0C, 16'h0000);
    wr(6'h00, 16'h0002);
    edges(3);
    chk("R6 hold while starting", active_src, 2'd0);
    wr(6'h0C, 16'h0001);
    edges(PLL_S + 2);
    chk("R6 switch to pll", active_src, 2'd2);
    wr(6'h00, 16'h0001);
    edges(1);
    chk("R6 switch to slow", active_src, 2'd1);
    wr(6'h00, 16'h0000);
    edges(1);
  endtask

  task automatic t_wait_slow();
    wr(6'h14, 16'h0200);
    go_sleep();
    chk("R7 drop", sys_clk_ready, 1'b0);
    edges(100);
    chk("R7 held in sleep", sys_clk_ready, 1'b0);
    wake();
    edges(2 * 256 - 1);
    chk("R8 slow before", sys_clk_ready, 1'b0);
    edges(1);
    chk("R8 slow release", sys_clk_ready, 1'b1);
  endtask

  task automatic t_wait_fast();
    wr(6'h14, 16'h0304);
    go_sleep();
    wake();
    edges(3 * 16 - 1);
    chk("R8 fast before", sys_clk_ready, 1'b0);
    edges(1);
    chk("R8 fast release", sys_clk_ready, 1'b1);
  endtask

  task automatic t_wait_zero();
    wr(6'h14, 16'h0000);
    go_sleep();
    wake();
    chk("R9 immediate release", sys_clk_ready, 1'b1);
  endtask

  task automatic t_overlap();
    logic [15:0] v;
    wr(6'h14, 16'h0204);
    go_sleep();
    @(negedge clk); wr_en = 1; addr = 6'h14; wr_data = 16'h0504; wake_evt = 1;
    @(negedge clk); wr_en = 0; wake_evt = 0;
    edges(2 * 16 - 1);
    chk("R10 old count before", sys_clk_ready, 1'b0);
    edges(1);
    chk("R10 old count release", sys_clk_ready, 1'b1);
    rd(6'h14, v); chk("R10 new value stored", v, 16'h0504);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_locked();
    t_unlock_relock();
    t_ready();
    t_select();
    t_wait_slow();
    t_wait_fast();
    t_wait_zero();
    t_overlap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule